// File: doc/BRIEF.md
# Link Error Resynchronization Controller

This block supervises one end of a point-to-point serial message link. A receive checker upstream hands it one strobe per arriving message. The strobe marks the message as a good data message, as a failed message (bad framing or check), or as an attention message that carries an identifier. From these strobes the controller keeps a receive-OK flag. It also tells the transmitter whether each outgoing message is a normal data message or an attention message that carries the local transmit ID.

A single error lowers receive-OK, and the next good data message raises it again. A second error in a row starts recovery. The controller then switches the transmitter to attention messages and keeps it there until an attention message arrives whose ID equals the local transmit ID. That match marks the link as synchronized. The next transmit slot goes back to data messages, and receive-OK comes back with the first good data message after that. The controller leaves reset in recovery, so a link always synchronizes before it reports OK.

Top module: `link_resync_ctrl`

## Requirements
- R1: While and after reset, before any strobe, `rx_ok` is 0 and `tx_attn` is 1.
- R2: A cycle with `rx_err` high makes `rx_ok` 0 from the next cycle on.
- R3: Two error messages with no good data message between them put the controller in recovery. An ignored attention message between them does not break the run. The next `tx_rdy` then sets `tx_attn` to 1.
- R4: An error followed by a good data message (`rx_data`) outside recovery clears the error run. The data message sets `rx_ok` to 1 in the next cycle, and recovery is not entered.
- R5: In recovery, the following messages leave the controller in recovery with `rx_ok` at 0: data messages, errors, and attention messages whose `rx_id` differs from `tx_id`.
- R6: An attention message with `rx_id` equal to `tx_id` received in recovery ends recovery. `rx_ok` stays 0 until the next good data message, and the next `tx_rdy` sets `tx_attn` to 0.
- R7: `tx_attn` changes only in the cycle after `tx_rdy`. It then takes the recovery state that held in the `tx_rdy` cycle (1 = send attention with `tx_id`, 0 = send data).
- R8: When several strobes are high in one cycle, `rx_err` takes priority over `rx_attn`, and `rx_attn` takes priority over `rx_data`. Only the winning strobe acts.
- R9: An attention message received outside recovery changes nothing: neither `rx_ok`, nor the error run, nor `tx_attn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 1 | Strobe: good data message received |
| rx_err | input | 1 | Strobe: failed message received |
| rx_attn | input | 1 | Strobe: attention message received |
| rx_id | input | ID_W | ID carried by the received attention message |
| tx_id | input | ID_W | Local transmit ID setting |
| tx_rdy | input | 1 | Strobe: transmitter starts a new message |
| rx_ok | output | 1 | Receive-OK status |
| tx_attn | output | 1 | 1 = send an attention message, 0 = send a data message |

## Verification
Each result is one register deep. `rx_ok` reflects a receive strobe in the cycle after that strobe. `tx_attn` reflects the recovery state in the cycle after a `tx_rdy` strobe. Recovery entered or left at a given edge therefore appears on `tx_attn` only after the following `tx_rdy`. The bench drives every strobe half a period before a rising edge. It advances a reference model at that edge and compares both outputs a nanosecond later, which is exactly the cycle in which each result is due. The directed checks place `tx_rdy` on purpose: they first confirm that `tx_attn` holds before the strobe, then that it moves after it.

// File: rtl/link_resync_ctrl.sv
module link_resync_ctrl #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_data,
  input  logic            rx_err,
  input  logic            rx_attn,
  input  logic [ID_W-1:0] rx_id,
  input  logic [ID_W-1:0] tx_id,
  input  logic            tx_rdy,
  output logic            rx_ok,
  output logic            tx_attn
);

  logic attn_mode;
  logic err_seen;
  wire  id_match = (rx_id == tx_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attn_mode <= 1'b1;
      err_seen  <= 1'b0;
      rx_ok     <= 1'b0;
      tx_attn   <= 1'b1;
    end else begin
      if (tx_rdy) tx_attn <= attn_mode;
      if (rx_err) begin
        rx_ok <= 1'b0;
        if (attn_mode) begin
          err_seen <= 1'b0;
        end else if (err_seen) begin
          attn_mode <= 1'b1;
          err_seen  <= 1'b0;
        end else begin
          err_seen <= 1'b1;
        end
      end else if (rx_attn) begin
        if (attn_mode && id_match) begin
          attn_mode <= 1'b0;
          err_seen  <= 1'b0;
        end
      end else if (rx_data) begin
        err_seen <= 1'b0;
        if (!attn_mode) rx_ok <= 1'b1;
      end
    end
  end

endmodule

module link_resync_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_data,
  input logic            rx_err,
  input logic            rx_attn,
  input logic [ID_W-1:0] rx_id,
  input logic [ID_W-1:0] tx_id,
  input logic            tx_rdy,
  input logic            rx_ok,
  input logic            tx_attn,
  input logic            attn_mode
);

  p_err_drops_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_ok);

  p_enter_needs_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attn_mode) |-> $past(rx_err));

  p_ok_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ok) |-> $past(rx_data && !rx_err && !rx_attn));

  p_ok_only_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |-> !attn_mode);

  p_exit_needs_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attn_mode) |-> $past(rx_attn && !rx_err && (rx_id == tx_id)));

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_rdy |=> $stable(tx_attn));

endmodule

bind link_resync_ctrl link_resync_chk #(.ID_W(ID_W)) u_chk (.*);

// File: tb/tb_link_resync_ctrl.sv
module tb_link_resync_ctrl;
  localparam int ID_W = 8;
  localparam logic [ID_W-1:0] MY_ID = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_data = 0, rx_err = 0, rx_attn = 0, tx_rdy = 0;
  logic [ID_W-1:0] rx_id = '0;
  logic [ID_W-1:0] tx_id = MY_ID;
  logic rx_ok, tx_attn;

  int n_run = 0, n_fail = 0;
  logic m_attn, m_err1, m_ok, m_tx;

  always #4 clk = ~clk;

  link_resync_ctrl #(.ID_W(ID_W)) dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic model_step(input logic e, input logic a, input logic d,
                            input logic [ID_W-1:0] id, input logic r);
    if (r) m_tx = m_attn;
    if (e) begin
      m_ok = 0;
      if (m_attn) m_err1 = 0;
      else if (m_err1) begin m_attn = 1; m_err1 = 0; end
      else m_err1 = 1;
    end else if (a) begin
      if (m_attn && id == tx_id) begin m_attn = 0; m_err1 = 0; end
    end else if (d) begin
      m_err1 = 0;
      if (!m_attn) m_ok = 1;
    end
  endtask

  task automatic step(input logic e, input logic a, input logic d,
                      input logic [ID_W-1:0] id, input logic r);
    @(negedge clk);
    rx_err = e; rx_attn = a; rx_data = d; rx_id = id; tx_rdy = r;
    @(posedge clk);
    model_step(e, a, d, id, r);
    #1;
    chk("R2 rx_ok vs model", rx_ok, m_ok);
    chk("R7 tx_attn vs model", tx_attn, m_tx);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_attn = 1; m_err1 = 0; m_ok = 0; m_tx = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rx_ok in reset", rx_ok, 1'b0);
    chk("R1 tx_attn in reset", tx_attn, 1'b1);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0);
    chk("R1 rx_ok after reset", rx_ok, 1'b0);

    step(0, 1, 0, 8'h3C, 1);
    chk("R5 wrong id keeps attention", tx_attn, 1'b1);
    step(0, 0, 1, 0, 0);
    chk("R5 data in recovery keeps rx_ok low", rx_ok, 1'b0);
    step(0, 1, 0, MY_ID, 0);
    chk("R6 rx_ok stays low after match", rx_ok, 1'b0);
    chk("R7 tx_attn holds without tx_rdy", tx_attn, 1'b1);
    step(0, 0, 0, 0, 1);
    chk("R6 tx_attn drops after match", tx_attn, 1'b0);
    step(0, 0, 1, 0, 0);
    chk("R6 first data raises rx_ok", rx_ok, 1'b1);

    step(1, 0, 0, 0, 0);
    chk("R2 error drops rx_ok", rx_ok, 1'b0);
    step(0, 0, 1, 0, 0);
    chk("R4 data after lone error raises rx_ok", rx_ok, 1'b1);
    step(1, 0, 0, 0, 1);
    chk("R4 lone error no recovery", tx_attn, 1'b0);
    step(0, 1, 0, MY_ID, 0);
    chk("R9 attention outside recovery ignored", rx_ok, 1'b0);
    step(1, 0, 0, 0, 0);
    chk("R7 tx_attn holds before tx_rdy", tx_attn, 1'b0);
    step(0, 0, 0, 0, 1);
    chk("R3 two errors enter recovery", tx_attn, 1'b1);

    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1);
    chk("R5 errors and data keep recovery", tx_attn, 1'b1);
    chk("R5 rx_ok low in recovery", rx_ok, 1'b0);
    step(1, 1, 0, MY_ID, 0);
    step(0, 0, 0, 0, 1);
    chk("R8 error beats matching attention", tx_attn, 1'b1);
    step(0, 1, 1, MY_ID, 0);
    chk("R8 attention beats data", rx_ok, 1'b0);
    step(0, 0, 0, 0, 1);
    chk("R8 matching attention acted", tx_attn, 1'b0);
    step(0, 0, 1, 0, 0);
    step(1, 0, 1, 0, 0);
    chk("R8 error beats data", rx_ok, 1'b0);

    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom_range(0, 99);
      logic e = (r < 12);
      logic a = (r >= 12 && r < 30) || (r > 95);
      logic d = (r >= 30 && r < 85) || (r > 97);
      logic [ID_W-1:0] id = ($urandom_range(0, 1) == 0) ? MY_ID : ID_W'($urandom);
      step(e, a, d, id, ($urandom_range(0, 3) == 0));
    end
    finish_run();
  end
endmodule